// File: doc/BRIEF.md
# Compressed Register-Pair Access Expander

This block is a purely combinational decoder for a 32-bit core front end. It takes one 16-bit compressed instruction and recognises four compressed forms that move a 64-bit value between memory and an even/odd pair of integer registers. Two of these forms use the stack pointer (x2) as the base. The other two use a register from the compact set x8..x15. When it recognises one of these forms, the block emits the equivalent 32-bit doubleword pair load or pair store word and raises a valid flag.

Some encodings are reserved. These are an odd data register, and a stack-pointer load whose destination is x0. For these the block raises an illegal flag instead of a valid flag. Every other 16-bit code is reported as not handled, so that the rest of the expander can process it. A configuration input states that the compressed single-precision float forms are enabled. Those forms share the same code points, so while the input is high all four pair forms are reported as not handled.

Top module: `pairx_expander`

## Requirements
- R1: Any code whose quadrant bits [1:0] and bits [15:13] are not one of the combinations 10/011, 10/111, 00/011 or 00/111 gives unhandled=1, valid=0, illegal=0 and a zero output word.
- R2: Quadrant 10 with bits [15:13]=011 is the stack-pointer pair load. It takes its destination from bits [11:7] and its offset from bits [12] (offset bit 5), [6:5] (offset bits 4:3) and [4:2] (offset bits 8:6). It expands to opcode 0x03 with funct3 3, the destination in bits [11:7], base x2 in bits [19:15] and the offset in bits [31:20].
- R3: A stack-pointer pair load with destination x0 is illegal.
- R4: Quadrant 10 with bits [15:13]=111 is the stack-pointer pair store. It takes its source from bits [6:2] and its offset from bits [12:10] (offset bits 5:3) and [9:7] (offset bits 8:6). It expands to opcode 0x23 with funct3 3, offset bits 4:0 in bits [11:7], base x2 in bits [19:15], the source in bits [24:20] and offset bits 11:5 in bits [31:25].
- R5: Quadrant 00 with bits [15:13]=011 is the register-based pair load. Its destination is 8 plus bits [4:2], its base is 8 plus bits [9:7], and its offset comes from bits [12:10] (offset bits 5:3) and [6:5] (offset bits 7:6). It uses the load encoding of R2.
- R6: Quadrant 00 with bits [15:13]=111 is the register-based pair store. Its source is 8 plus bits [4:2], and its base and offset come from the same fields as in R5. It uses the store encoding of R4.
- R7: In all four forms, a data register with bit 0 set makes the code illegal. An odd base register is accepted.
- R8: Offsets are zero-extended and are multiples of 8. The largest offset is 504 for the stack-pointer forms and 248 for the register-based forms.
- R9: While the float-compressed enable is high, the four pair forms are reported as not handled, with a zero word.
- R10: Exactly one of valid, illegal and unhandled is high. The output word is zero unless valid is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| cinst_i | input | 16 | Compressed instruction |
| fcomp_en_i | input | 1 | Compressed single-precision float forms enabled |
| xinst_o | output | 32 | Expanded 32-bit instruction word, zero unless valid |
| valid_o | output | 1 | Input was a legal pair form and has been expanded |
| illegal_o | output | 1 | Input was a pair form with a reserved register choice |
| unhandled_o | output | 1 | Input is not a pair form under the current configuration |

## Verification
The immediate assertions assume the input is a settled two-valued code. They check the output only when valid is high, or they check properties that hold for every input, such as the one-hot status and the configuration override. The bench meets that assumption by driving each code one clock after the previous one and sampling at the opposite edge. It sweeps every 16-bit code under both values of the enable, so the assertions see the full input space. The expected word is built in the bench from integer weights of the offset bits, without reusing the design's bit concatenations.

// File: rtl/pairx_pkg.sv
package pairx_pkg;
  localparam int CI_W   = 16;
  localparam int XI_W   = 32;
  localparam int REG_W  = 5;
  localparam int CREG_W = 3;
  localparam int IMM_W  = 12;
  localparam int OFF_W  = 9;
  localparam int PAD_W  = IMM_W - OFF_W;

  localparam logic [6:0]       OPC_LOAD  = 7'h03;
  localparam logic [6:0]       OPC_STORE = 7'h23;
  localparam logic [2:0]       F3_PAIR   = 3'b011;
  localparam logic [REG_W-1:0] SP_REG    = 5'd2;

  typedef enum logic [2:0] {
    FORM_NONE,
    FORM_SPLD,
    FORM_SPST,
    FORM_RGLD,
    FORM_RGST
  } form_e;

  typedef struct packed {
    logic             is_store;
    logic [REG_W-1:0] data;
    logic [REG_W-1:0] base;
    logic [OFF_W-1:0] off;
  } pair_op_t;

  function automatic logic [REG_W-1:0] creg_expand(input logic [CREG_W-1:0] c);
    return {2'b01, c};
  endfunction

  function automatic logic [XI_W-1:0] enc_load(input logic [REG_W-1:0] rd,
                                               input logic [REG_W-1:0] rs1,
                                               input logic [IMM_W-1:0] imm);
    return {imm, rs1, F3_PAIR, rd, OPC_LOAD};
  endfunction

  function automatic logic [XI_W-1:0] enc_store(input logic [REG_W-1:0] rs2,
                                                input logic [REG_W-1:0] rs1,
                                                input logic [IMM_W-1:0] imm);
    return {imm[11:5], rs2, rs1, F3_PAIR, imm[4:0], OPC_STORE};
  endfunction
endpackage

// File: rtl/pairx_classify.sv
module pairx_classify
  import pairx_pkg::*;
(
  input  logic [15:13] op_hi_i,
  input  logic [1:0]   quad_i,
  input  logic         fcomp_en_i,
  output form_e        form_o
);
  always_comb begin
    form_o = FORM_NONE;
    if (!fcomp_en_i) begin
      unique case ({quad_i, op_hi_i})
        5'b10_011: form_o = FORM_SPLD;
        5'b10_111: form_o = FORM_SPST;
        5'b00_011: form_o = FORM_RGLD;
        5'b00_111: form_o = FORM_RGST;
        default:   form_o = FORM_NONE;
      endcase
    end
  end
endmodule

// File: rtl/pairx_fields.sv
module pairx_fields
  import pairx_pkg::*;
(
  input  logic [12:2] body_i,
  input  form_e       form_i,
  output pair_op_t    op_o,
  output logic        data_odd_o,
  output logic        data_zero_o
);
  always_comb begin
    op_o = '0;
    unique case (form_i)
      FORM_SPLD: begin
        op_o.data = body_i[11:7];
        op_o.base = SP_REG;
        op_o.off  = {body_i[4:2], body_i[12], body_i[6:5], 3'b000};
      end
      FORM_SPST: begin
        op_o.is_store = 1'b1;
        op_o.data     = body_i[6:2];
        op_o.base     = SP_REG;
        op_o.off      = {body_i[9:7], body_i[12:10], 3'b000};
      end
      FORM_RGLD, FORM_RGST: begin
        op_o.is_store = (form_i == FORM_RGST);
        op_o.data     = creg_expand(body_i[4:2]);
        op_o.base     = creg_expand(body_i[9:7]);
        op_o.off      = {1'b0, body_i[6:5], body_i[12:10], 3'b000};
      end
      default: op_o = '0;
    endcase
  end

  assign data_odd_o  = op_o.data[0];
  assign data_zero_o = (op_o.data == '0);
endmodule

// File: rtl/pairx_encode.sv
module pairx_encode
  import pairx_pkg::*;
(
  input  pair_op_t        op_i,
  output logic [XI_W-1:0] word_o
);
  logic [IMM_W-1:0] imm;
  assign imm    = {{PAD_W{1'b0}}, op_i.off};
  assign word_o = op_i.is_store ? enc_store(op_i.data, op_i.base, imm)
                                : enc_load(op_i.data, op_i.base, imm);
endmodule

// File: rtl/pairx_expander.sv
module pairx_expander
  import pairx_pkg::*;
(
  input  logic [15:0] cinst_i,
  input  logic        fcomp_en_i,
  output logic [31:0] xinst_o,
  output logic        valid_o,
  output logic        illegal_o,
  output logic        unhandled_o
);
  form_e           form;
  pair_op_t        op;
  logic            data_odd;
  logic            data_zero;
  logic [XI_W-1:0] word;
  logic            is_pair;
  logic            reserved;

  pairx_classify u_classify (
    .op_hi_i    (cinst_i[15:13]),
    .quad_i     (cinst_i[1:0]),
    .fcomp_en_i (fcomp_en_i),
    .form_o     (form)
  );

  pairx_fields u_fields (
    .body_i      (cinst_i[12:2]),
    .form_i      (form),
    .op_o        (op),
    .data_odd_o  (data_odd),
    .data_zero_o (data_zero)
  );

  pairx_encode u_encode (
    .op_i   (op),
    .word_o (word)
  );

  assign is_pair     = (form != FORM_NONE);
  assign reserved    = data_odd | ((form == FORM_SPLD) & data_zero);
  assign illegal_o   = is_pair & reserved;
  assign valid_o     = is_pair & ~reserved;
  assign unhandled_o = ~is_pair;
  assign xinst_o     = valid_o ? word : '0;

  always_comb begin
    AST_ONE_STATUS: assert ($countones({valid_o, illegal_o, unhandled_o}) == 1); // R10
    AST_QUIET_WORD: assert (valid_o || xinst_o == '0); // R10
    AST_FCOMP_OFF: assert (!fcomp_en_i || unhandled_o); // R9
    AST_EVEN_DATA: assert (!valid_o || (xinst_o[5] ? !xinst_o[20] : !xinst_o[7])); // R7
    AST_OFF_ALIGN: assert (!valid_o || (xinst_o[5] ? xinst_o[9:7] == 3'b000
                                                   : xinst_o[22:20] == 3'b000)); // R8
    AST_SP_BASE: assert (!(valid_o && cinst_i[1:0] == 2'b10) || xinst_o[19:15] == 5'd2); // R2
    AST_CREG_BASE: assert (!(valid_o && cinst_i[1:0] == 2'b00) || xinst_o[19:18] == 2'b01); // R5
    AST_SPLD_RD: assert (!(valid_o && cinst_i[1:0] == 2'b10 && !xinst_o[5])
                         || xinst_o[11:7] != 5'd0); // R3
  end
endmodule

// File: tb/pairx_expander_bench.sv
module pairx_expander_bench;
  localparam int PERIOD = 10;
  localparam int WATCHDOG = 190000;

  logic        clk = 1'b0;
  logic [15:0] cinst;
  logic        fcomp_en;
  logic [31:0] xinst;
  logic        valid, illegal, unhandled;
  int          total = 0;
  int          bad = 0;
  int          cycles = 0;
  bit          done = 1'b0;

  always #(PERIOD/2) clk = ~clk;

  pairx_expander u_pairx_expander (
    .cinst_i     (cinst),
    .fcomp_en_i  (fcomp_en),
    .xinst_o     (xinst),
    .valid_o     (valid),
    .illegal_o   (illegal),
    .unhandled_o (unhandled)
  );

  logic [31:0] e_word;
  logic        e_v, e_il, e_un;
  string       e_tag;

  task automatic model(input logic [15:0] c, input logic f);
    int q, f3, off, dr, br;
    bit ld, pair;
    q  = int'(c[1:0]);
    f3 = int'(c[15:13]);
    pair = (q == 2 || q == 0) && (f3 == 3 || f3 == 7);
    e_word = 0; e_v = 0; e_il = 0; e_un = 0;
    if (!pair || f) begin
      e_un  = 1;
      e_tag = pair ? "R9" : "R1";
      return;
    end
    ld = (f3 == 3);
    if (q == 2) begin
      br = 2;
      if (ld) begin
        dr  = int'(c[11:7]);
        off = 32 * int'(c[12]) + 8 * int'(c[6:5]) + 64 * int'(c[4:2]);
        e_tag = "R2";
      end else begin
        dr  = int'(c[6:2]);
        off = 8 * int'(c[12:10]) + 64 * int'(c[9:7]);
        e_tag = "R4";
      end
    end else begin
      dr  = 8 + int'(c[4:2]);
      br  = 8 + int'(c[9:7]);
      off = 8 * int'(c[12:10]) + 64 * int'(c[6:5]);
      e_tag = ld ? "R5" : "R6";
    end
    if (dr % 2 == 1) begin
      e_il = 1; e_tag = "R7";
    end else if (q == 2 && ld && dr == 0) begin
      e_il = 1; e_tag = "R3";
    end else begin
      e_v = 1;
      if (ld)
        e_word = (off << 20) + (br << 15) + (3 << 12) + (dr << 7) + 3;
      else
        e_word = ((off / 32) << 25) + (dr << 20) + (br << 15) + (3 << 12)
               + ((off % 32) << 7) + 32'h23;
    end
  endtask

  task automatic apply(input logic [15:0] c, input logic f, input string force_tag);
    @(posedge clk);
    #1;
    cinst = c;
    fcomp_en = f;
    @(negedge clk);
    model(c, f);
    if (force_tag.len() != 0) e_tag = force_tag;
    total++;
    if (xinst !== e_word || valid !== e_v || illegal !== e_il || unhandled !== e_un) begin
      bad++;
      $display("FAIL %s c=%h f=%0b got word=%h v=%0b il=%0b un=%0b exp word=%h v=%0b il=%0b un=%0b",
               e_tag, c, f, xinst, valid, illegal, unhandled, e_word, e_v, e_il, e_un);
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > WATCHDOG && !done) begin
      done = 1'b1;
      bad++;
      total++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    cinst = 16'h0001;
    fcomp_en = 1'b0;
    // R1 start state: a non-pair code
    apply(16'h0001, 1'b0, "R1");
    // R8 largest stack offset: load x10 with all offset bits set -> 504
    apply({3'b011, 1'b1, 5'd10, 5'b11111, 2'b10}, 1'b0, "R8");
    // R8 largest register offset: store x8 base x9 -> 248
    apply({3'b111, 3'b111, 3'b001, 2'b11, 3'b000, 2'b00}, 1'b0, "R8");
    // R7 odd base accepted (base x9), even data x14
    apply({3'b011, 3'b000, 3'b001, 2'b00, 3'b110, 2'b00}, 1'b0, "R7");
    // R3 stack load to x0
    apply({3'b011, 1'b0, 5'd0, 5'd0, 2'b10}, 1'b0, "R3");
    // R9 same legal code with the float forms enabled
    apply({3'b011, 1'b1, 5'd10, 5'b11111, 2'b10}, 1'b1, "R9");
    // R10 store from x0 is legal and zero-sourced
    apply({3'b111, 6'd0, 5'd0, 2'b10}, 1'b0, "R10");
    // full sweep covering R1, R2, R4, R5, R6, R7, R9, R10
    for (int fv = 0; fv < 2; fv++)
      for (int cv = 0; cv < 65536; cv++)
        apply(cv[15:0], fv[0], "");
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule